// File: doc/BRIEF.md
# Display Character Output Port

This block is a memory-mapped output port that sits between a 16-bit processor's load/store path and a character display device. Software sees two 16-bit registers. One is a status word. It carries a ready flag and an interrupt-enable flag. The other is a data word that takes the character to be shown.

Software waits until the ready flag reads set. On a 16-bit word this shows up as a negative value. It then stores a character into the data word. That store clears the ready flag. The low eight bits go to the device with a one-clock valid pulse. The device returns a one-clock done pulse once it has shown the character, and this sets the ready flag again. A store to the data word while the flag is clear is thrown away.

When interrupts are enabled and the port is ready, the port raises an interrupt request. Software can then use the request instead of polling.

Top module: `disp_out_port`

## Requirements
- R1: After reset, the status word reads 0x8000 (ready set, interrupt enable clear), `irq` and `chr_vld` are low, and the data word reads 0x0000.
- R2: A read of address 0xFE04 returns the ready flag in bit 15 and the interrupt enable in bit 14, with all other bits zero.
- R3: A write to address 0xFE06 while ready is set is accepted. On the next cycle `chr_vld` is high for exactly one clock, `chr_out` equals write-data bits [7:0], and the ready flag reads zero.
- R4: A write to address 0xFE06 while ready is clear is discarded. No `chr_vld` pulse follows, and `chr_out` and the data-word read value stay unchanged.
- R5: A `chr_done` pulse sets the ready flag, and the flag reads one from the next cycle.
- R6: A write to 0xFE04 loads the interrupt enable from write-data bit 14. Write-data bit 15 has no effect on the ready flag.
- R7: `irq` is high exactly when the ready flag and the interrupt enable are both set.
- R8: A read of 0xFE06 returns the last accepted character in bits [7:0], with bits [15:8] zero.
- R9: Any access to an address other than 0xFE04 or 0xFE06, or with `bus_sel` low, reads as zero and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational, zero when not addressed |
| chr_out | output | 8 | Character presented to the display |
| chr_vld | output | 1 | One-clock pulse per accepted character |
| chr_done | input | 1 | One-clock pulse from the display when the character is shown |
| irq | output | 1 | Interrupt request |

## Verification
The assertions are checked on every cycle. They cover the single-clock valid pulse and the character it carries after an accepted store. They also cover the silence that follows a discarded store, the return of the ready flag after a done pulse, the gating of the interrupt request, and the status bit seen by a read.

Some properties are shown only by the bench's scenarios:
- whether every one of the 256 character codes survives the full write–drop–done cycle;
- whether stray addresses around the device window stay inert;
- whether a set bit 15 in a status write is really ignored.

// File: rtl/disp_out_port.sv
module disp_out_port #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CHAR_W = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hFE04,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 16'hFE06,
  parameter int RDY_BIT = 15,
  parameter int IE_BIT  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [CHAR_W-1:0] chr_out,
  output logic              chr_vld,
  input  logic              chr_done,
  output logic              irq
);

  logic              rdy_q, ie_q, vld_q;
  logic [CHAR_W-1:0] chr_q;
  logic              stat_hit, data_hit, accept;
  logic              unused_wbits;

  assign stat_hit = bus_sel && (bus_addr == STAT_ADDR);
  assign data_hit = bus_sel && (bus_addr == DATA_ADDR);
  assign accept   = data_hit && bus_we && rdy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_q <= 1'b1;
      ie_q  <= 1'b0;
      vld_q <= 1'b0;
      chr_q <= '0;
    end else begin
      vld_q <= accept;
      if (accept) begin
        rdy_q <= 1'b0;
        chr_q <= bus_wdata[CHAR_W-1:0];
      end else if (chr_done) begin
        rdy_q <= 1'b1;
      end
      if (stat_hit && bus_we) ie_q <= bus_wdata[IE_BIT];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (stat_hit && !bus_we) begin
      bus_rdata[RDY_BIT] = rdy_q;
      bus_rdata[IE_BIT]  = ie_q;
    end else if (data_hit && !bus_we) begin
      bus_rdata[CHAR_W-1:0] = chr_q;
    end
  end

  assign chr_out = chr_q;
  assign chr_vld = vld_q;
  assign irq     = rdy_q & ie_q;

  assign unused_wbits = ^{bus_wdata[DATA_W-1:IE_BIT+1], bus_wdata[IE_BIT-1:CHAR_W]};

endmodule

// File: rtl/disp_out_port_chk.sv
module disp_out_port_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CHAR_W = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hFE04,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 16'hFE06,
  parameter int RDY_BIT = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [CHAR_W-1:0] chr_out,
  input logic              chr_vld,
  input logic              chr_done,
  input logic              irq,
  input logic              rdy_q,
  input logic              ie_q
);

  logic dwr;
  assign dwr = bus_sel && bus_we && (bus_addr == DATA_ADDR);

  AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    chr_vld |=> !chr_vld); // R3
  AST_VLD_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (dwr && rdy_q) |=> (chr_vld && !rdy_q && chr_out == $past(bus_wdata[CHAR_W-1:0]))); // R3
  AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (dwr && !rdy_q) |=> (!chr_vld && $stable(chr_out))); // R4
  AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (chr_done && !dwr) |=> rdy_q); // R5
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy_q || !ie_q) |-> !irq); // R7
  AST_STATUS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && bus_addr == STAT_ADDR) |-> (bus_rdata[RDY_BIT] == rdy_q)); // R2

endmodule

bind disp_out_port disp_out_port_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHAR_W(CHAR_W),
  .STAT_ADDR(STAT_ADDR), .DATA_ADDR(DATA_ADDR), .RDY_BIT(RDY_BIT)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .chr_out(chr_out), .chr_vld(chr_vld), .chr_done(chr_done), .irq(irq),
  .rdy_q(rdy_q), .ie_q(ie_q)
);

// File: tb/disp_out_port_tb_top.sv
module disp_out_port_tb_top;
  logic        clk = 0, rst_n = 0;
  logic        bus_sel = 0, bus_we = 0, chr_done = 0;
  logic [15:0] bus_addr = '0, bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [7:0]  chr_out;
  logic        chr_vld, irq;
  int n_chk = 0, n_fail = 0;
  logic [15:0] rv;

  always #5 clk = ~clk;

  disp_out_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .chr_out(chr_out), .chr_vld(chr_vld), .chr_done(chr_done), .irq(irq)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [15:0] a);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 rv = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic done_pulse();
    @(negedge clk);
    chr_done = 1;
    @(negedge clk);
    chr_done = 0;
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(16'hFE04); chk(rv == 16'h8000, "R1 status", rv, 16'h8000);
    chk(!irq && !chr_vld, "R1 irq/vld", {irq, chr_vld}, 0);
    rd(16'hFE06); chk(rv == 16'h0000, "R1 data", rv, 0);

    // R3 R4 R5 R8 across every character code
    for (int c = 0; c < 256; c++) begin
      logic [7:0] ch;
      ch = 8'(c);
      wr(16'hFE06, {8'hA5, ch});
      chk(chr_vld == 1'b1, "R3 vld", chr_vld, 1);
      chk(chr_out == ch, "R3 char", chr_out, ch);
      rd(16'hFE04);
      chk(chr_vld == 1'b0, "R3 one-cycle", chr_vld, 0);
      chk(rv == 16'h0000, "R3 ready cleared", rv, 0);
      wr(16'hFE06, {8'h00, ~ch});
      chk(chr_vld == 1'b0, "R4 no pulse", chr_vld, 0);
      chk(chr_out == ch, "R4 char kept", chr_out, ch);
      rd(16'hFE06); chk(rv == {8'h00, ch}, "R8 data read", rv, {8'h00, ch});
      done_pulse();
      rd(16'hFE04); chk(rv == 16'h8000, "R5 ready back", rv, 16'h8000);
    end

    // R6 R7 over ready x ie combinations
    for (int k = 0; k < 4; k++) begin
      logic want_rdy, want_ie;
      want_rdy = k[0]; want_ie = k[1];
      if (!want_rdy) wr(16'hFE06, 16'h0041);
      wr(16'hFE04, {~want_rdy, want_ie, 14'h3FFF});
      rd(16'hFE04);
      chk(rv == {want_rdy, want_ie, 14'h0}, "R6 status", rv, {want_rdy, want_ie, 14'h0});
      chk(irq == (want_rdy && want_ie), "R7 irq", irq, want_rdy && want_ie);
      if (!want_rdy) done_pulse();
      wr(16'hFE04, 16'h0000);
    end

    // R9 address sweep around the window
    wr(16'hFE06, 16'h005A); done_pulse();
    for (int a = 16'hFDF0; a <= 16'hFE1F; a++) begin
      if (a == 16'hFE04 || a == 16'hFE06) continue;
      rd(16'(a)); chk(rv == 16'h0, "R9 stray read", rv, 0);
      wr(16'(a), 16'hFFFF);
      chk(chr_vld == 1'b0, "R9 stray write", chr_vld, 0);
    end
    @(negedge clk); bus_sel = 0; bus_we = 1; bus_addr = 16'hFE06; bus_wdata = 16'h0033;
    @(negedge clk); bus_we = 0;
    chk(chr_vld == 1'b0 && chr_out == 8'h5A, "R9 unselected", chr_out, 8'h5A);
    rd(16'hFE04); chk(rv == 16'h8000, "R9 status intact", rv, 16'h8000);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule